// File: doc/BRIEF.md
# Host Register Port with Direct and Indexed Addressing

This block is the host-side register port of a video scan converter. A host on a small 8-bit bus, with an active-low select, active-low read and write strobes and a 4-bit address, reaches a bank of up to sixteen parameter and mode registers. The values it holds are the filter enable bits and the vertical back-porch and active-end line numbers. The filter datapath and the timing generator read these values from dedicated outputs.

A strap input picks one of two addressing schemes. In direct mode the 4-bit address selects the register itself. In indexed mode the host first writes a register number to an index location at host address 0, and then reads or writes the chosen register through host address 1. A second strap lets two hardware pins take the place of the stored filter enable bits. A third strap picks the reset defaults of the vertical position registers.

Write strobes are brought into the system clock domain through a synchronizer. A write is committed on the rising edge of the synchronized strobe, using the address, data and select values captured while the strobe was low. Reads are combinational from the register contents and appear on a split data bus that has an explicit output enable.

Top module: `scan_host_regs`

## Requirements
- R1: While `cs_n` is high, a write strobe changes no register and the bus is not driven (`bus_oe` = 0).
- R2: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both low, and `bus_out` is 00h while `bus_oe` is 0. A write takes effect within five clock cycles of the rising edge of `wr_n`, using the address and data held while `wr_n` was low.
- R3: With `addr_direct` = 1, `addr` selects the register index directly. The register indices are: 2h mode, 8h back-porch low byte, 9h back-porch high bits, Ah active-end low byte, Bh active-end high bits.
- R4: With `addr_direct` = 0, host address 0h reads and writes the 4-bit index register (bits 3:0, upper bits read 0), and host address 1h reads and writes the register that the index selects. Other host addresses read 00h and ignore writes.
- R5: An active-high `rst` clears the index register and the mode register to 0.
- R6: Mode register bit 0 is the vertical filter enable and bit 1 is the horizontal filter enable. When `pin_prio` = 1, `vfil_en` and `hfil_en` follow `vfil_pin` and `hfil_pin`. When `pin_prio` = 0, they follow the register bits and the pins have no effect.
- R7: On reset the back porch and active end become 45 and 530 when `center_strap` = 1, and 35 and 514 when `center_strap` = 0.
- R8: Reading an unimplemented index returns 00h, and writing one changes no implemented register.
- R9: `vbp_line` and `vact_end` are the high register bits 1:0 placed above the low byte, and the high registers read back with bits 7:2 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous to clk |
| addr_direct | input | 1 | 1: direct addressing, 0: index/data addressing |
| addr | input | 4 | Host address |
| bus_in | input | 8 | Host write data |
| bus_out | output | 8 | Host read data |
| bus_oe | output | 1 | Drive enable for the host data bus |
| pin_prio | input | 1 | 1: filter enables come from pins |
| vfil_pin | input | 1 | Vertical filter enable pin |
| hfil_pin | input | 1 | Horizontal filter enable pin |
| center_strap | input | 1 | Selects the vertical position reset defaults |
| vfil_en | output | 1 | Effective vertical filter enable |
| hfil_en | output | 1 | Effective horizontal filter enable |
| vbp_line | output | 10 | Vertical back-porch line number |
| vact_end | output | 10 | Vertical active-end line number |

## Verification
Random bus cycles mix both addressing modes, selected and deselected accesses, implemented and unimplemented indices, and host addresses other than 0 and 1. This separates a design that decodes the index path wrongly from one that gates on select wrongly, because a wrong decode and a missed gate leave different register contents behind. Directed cases reset under both strap values, to tell the two default sets apart, and toggle the filter pins with pin priority on and off, to show whether the pins or the stored bits drive the enables. The position outputs are compared after every operation, so a write that lands in the wrong high or low half shows up at once.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
    localparam logic [3:0] IX_MODE  = 4'h2;
    localparam logic [3:0] IX_BP_LO = 4'h8;
    localparam logic [3:0] IX_BP_HI = 4'h9;
    localparam logic [3:0] IX_AE_LO = 4'hA;
    localparam logic [3:0] IX_AE_HI = 4'hB;

    localparam int DEF_BP_CENTER = 45;
    localparam int DEF_AE_CENTER = 530;
    localparam int DEF_BP_LOW    = 35;
    localparam int DEF_AE_LOW    = 514;

    typedef enum logic [1:0] {
        HOST_IDX  = 2'd0,
        HOST_DATA = 2'd1,
        HOST_NONE = 2'd2
    } host_sel_e;
endpackage

// File: rtl/hreg_wsync.sv
module hreg_wsync #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic              cap_cs_n,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              last;
        logic              cs_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ws_t;

    ws_t q, d;
    logic strobe_s;

    assign strobe_s = q.sync[SYNC_N-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_N-2:0], wr_n};
        d.last = strobe_s;
        if (!strobe_s) begin
            d.cs_n = cs_n;
            d.addr = addr;
            d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{sync: '1, last: 1'b1, cs_n: 1'b1, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign commit   = strobe_s && !q.last;
    assign cap_cs_n = q.cs_n;
    assign cap_addr = q.addr;
    assign cap_data = q.data;

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit); // R2
endmodule

// File: rtl/hreg_bank.sv
module hreg_bank
    import hreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int POS_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              center_strap,
    input  logic              addr_direct,
    input  logic              commit,
    input  logic              w_cs_n,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [DATA_W-1:0] w_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        mode_bits,
    output logic [POS_W-1:0]  vbp,
    output logic [POS_W-1:0]  vae
);
    localparam int HI_W = POS_W - DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] idx;
        logic [1:0]        mode;
        logic [POS_W-1:0]  bp;
        logic [POS_W-1:0]  ae;
    } bank_t;

    bank_t q, d;
    logic  wen_reg, wen_idx;
    logic [ADDR_W-1:0] tgt;

    function automatic host_sel_e host_sel(input logic [ADDR_W-1:0] a);
        if (a == ADDR_W'(0))      return HOST_IDX;
        else if (a == ADDR_W'(1)) return HOST_DATA;
        else                      return HOST_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] reg_read(input bank_t s, input logic [ADDR_W-1:0] ix);
        logic [DATA_W-1:0] r;
        r = '0;
        case (4'(ix))
            IX_MODE:  r = DATA_W'(s.mode);
            IX_BP_LO: r = s.bp[DATA_W-1:0];
            IX_BP_HI: r = DATA_W'(s.bp[POS_W-1:DATA_W]);
            IX_AE_LO: r = s.ae[DATA_W-1:0];
            IX_AE_HI: r = DATA_W'(s.ae[POS_W-1:DATA_W]);
            default:  r = '0;
        endcase
        return r;
    endfunction

    always_comb begin
        d       = q;
        tgt     = addr_direct ? w_addr : q.idx;
        wen_idx = commit && !w_cs_n && !addr_direct && (host_sel(w_addr) == HOST_IDX);
        wen_reg = commit && !w_cs_n && (addr_direct || (host_sel(w_addr) == HOST_DATA));
        if (wen_idx) begin
            d.idx = w_data[ADDR_W-1:0];
        end
        if (wen_reg) begin
            case (4'(tgt))
                IX_MODE:  d.mode = w_data[1:0];
                IX_BP_LO: d.bp[DATA_W-1:0] = w_data;
                IX_BP_HI: d.bp[POS_W-1:DATA_W] = w_data[HI_W-1:0];
                IX_AE_LO: d.ae[DATA_W-1:0] = w_data;
                IX_AE_HI: d.ae[POS_W-1:DATA_W] = w_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.idx  <= '0;
            q.mode <= '0;
            q.bp   <= center_strap ? POS_W'(DEF_BP_CENTER) : POS_W'(DEF_BP_LOW);
            q.ae   <= center_strap ? POS_W'(DEF_AE_CENTER) : POS_W'(DEF_AE_LOW);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (addr_direct) begin
            rd_data = reg_read(q, rd_addr);
        end else begin
            case (host_sel(rd_addr))
                HOST_IDX:  rd_data = DATA_W'(q.idx);
                HOST_DATA: rd_data = reg_read(q, q.idx);
                default:   rd_data = '0;
            endcase
        end
    end

    assign mode_bits = q.mode;
    assign vbp       = q.bp;
    assign vae       = q.ae;

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(q)); // R2
    AST_CS_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
        (commit && w_cs_n) |=> $stable(q)); // R1
    AST_RESET_DEFAULT: assert property (@(posedge clk)
        rst |=> (vbp == ($past(center_strap) ? POS_W'(DEF_BP_CENTER) : POS_W'(DEF_BP_LOW))
                 && vae == ($past(center_strap) ? POS_W'(DEF_AE_CENTER) : POS_W'(DEF_AE_LOW)))); // R7
endmodule

// File: rtl/scan_host_regs.sv
module scan_host_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int POS_W  = 10,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              addr_direct,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              pin_prio,
    input  logic              vfil_pin,
    input  logic              hfil_pin,
    input  logic              center_strap,
    output logic              vfil_en,
    output logic              hfil_en,
    output logic [POS_W-1:0]  vbp_line,
    output logic [POS_W-1:0]  vact_end
);
    logic              wr_commit, wr_cs_n;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [1:0]        mode_bits;

    hreg_wsync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_wsync (
        .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .addr(addr), .din(bus_in),
        .commit(wr_commit), .cap_cs_n(wr_cs_n), .cap_addr(wr_addr), .cap_data(wr_data)
    );

    hreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W)) u_bank (
        .clk(clk), .rst(rst), .center_strap(center_strap), .addr_direct(addr_direct),
        .commit(wr_commit), .w_cs_n(wr_cs_n), .w_addr(wr_addr), .w_data(wr_data),
        .rd_addr(addr), .rd_data(rd_data), .mode_bits(mode_bits),
        .vbp(vbp_line), .vae(vact_end)
    );

    always_comb begin
        bus_oe  = !cs_n && !rd_n;
        bus_out = bus_oe ? rd_data : '0;
        vfil_en = pin_prio ? vfil_pin : mode_bits[0];
        hfil_en = pin_prio ? hfil_pin : mode_bits[1];
    end

    AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!pin_prio && !wr_commit) |=> (pin_prio || $stable({vfil_en, hfil_en}))); // R6
endmodule

// File: tb/tb_scan_host_regs.sv
module tb_scan_host_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       addr_direct = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       pin_prio = 1'b0, vfil_pin = 1'b0, hfil_pin = 1'b0;
    logic       center_strap = 1'b1;
    logic       vfil_en, hfil_en;
    logic [9:0] vbp_line, vact_end;

    int total = 0;
    int bad   = 0;

    logic [3:0] m_idx;
    logic [1:0] m_mode;
    logic [9:0] m_bp, m_ae;

    always #2 clk = ~clk;

    scan_host_regs dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr_direct(addr_direct), .addr(addr), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .pin_prio(pin_prio), .vfil_pin(vfil_pin), .hfil_pin(hfil_pin),
        .center_strap(center_strap), .vfil_en(vfil_en), .hfil_en(hfil_en),
        .vbp_line(vbp_line), .vact_end(vact_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_val(input logic [3:0] ix);
        case (ix)
            4'h2:    return {6'b0, m_mode};
            4'h8:    return m_bp[7:0];
            4'h9:    return {6'b0, m_bp[9:8]};
            4'hA:    return m_ae[7:0];
            4'hB:    return {6'b0, m_ae[9:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic dir, input logic [3:0] a);
        if (dir)          return reg_val(a);
        else if (a == 0)  return {4'b0, m_idx};
        else if (a == 1)  return reg_val(m_idx);
        else              return 8'h00;
    endfunction

    function automatic logic [3:0] pick_ix();
        case ($urandom_range(0, 6))
            0: return 4'h2;
            1: return 4'h8;
            2: return 4'h9;
            3: return 4'hA;
            4: return 4'hB;
            default: return 4'($urandom_range(0, 15));
        endcase
    endfunction

    task automatic model_write(input logic [3:0] ix, input logic [7:0] v);
        case (ix)
            4'h2: m_mode = v[1:0];
            4'h8: m_bp[7:0] = v;
            4'h9: m_bp[9:8] = v[1:0];
            4'hA: m_ae[7:0] = v;
            4'hB: m_ae[9:8] = v[1:0];
            default: ;
        endcase
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        center_strap = strap;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_idx  = '0;
        m_mode = '0;
        m_bp   = strap ? 10'd45 : 10'd35;
        m_ae   = strap ? 10'd530 : 10'd514;
        @(negedge clk);
    endtask

    task automatic do_write(input logic dir, input logic sel_n, input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        addr_direct = dir;
        cs_n = sel_n;
        addr = a;
        bus_in = v;
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 bus idle during write", int'(bus_oe), 0);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        if (!sel_n) begin
            if (dir)          model_write(a, v);
            else if (a == 0)  m_idx = v[3:0];
            else if (a == 1)  model_write(m_idx, v);
        end
    endtask

    task automatic do_read(input logic dir, input logic sel_n, input logic [3:0] a, input string req);
        @(negedge clk);
        addr_direct = dir;
        cs_n = sel_n;
        addr = a;
        rd_n = 1'b0;
        #1;
        chk({req, " oe"}, int'(bus_oe), sel_n ? 0 : 1);
        chk({req, " data"}, int'(bus_out), sel_n ? 0 : int'(exp_read(dir, a)));
        @(negedge clk);
        rd_n = 1'b1;
        #1;
        chk("R2 oe released", int'(bus_oe), 0);
        cs_n = 1'b1;
    endtask

    task automatic chk_outputs(input string tag);
        chk({tag, " R9 vbp"}, int'(vbp_line), int'(m_bp));
        chk({tag, " R9 vae"}, int'(vact_end), int'(m_ae));
        chk({tag, " R6 vfil"}, int'(vfil_en), pin_prio ? int'(vfil_pin) : int'(m_mode[0]));
        chk({tag, " R6 hfil"}, int'(hfil_en), pin_prio ? int'(hfil_pin) : int'(m_mode[1]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));

        do_reset(1'b1);
        chk("R7 center bp", int'(vbp_line), 45);
        chk("R7 center ae", int'(vact_end), 530);
        chk("R5 filters off", int'({vfil_en, hfil_en}), 0);
        do_read(1'b1, 1'b0, 4'h2, "R5 mode reset");
        do_read(1'b0, 1'b0, 4'h0, "R5 index reset");
        do_read(1'b1, 1'b0, 4'h9, "R9 bp hi read");

        do_reset(1'b0);
        chk("R7 low bp", int'(vbp_line), 35);
        chk("R7 low ae", int'(vact_end), 514);

        do_write(1'b1, 1'b0, 4'h8, 8'hA5);
        chk_outputs("R3 direct lo");
        do_write(1'b1, 1'b1, 4'h8, 8'h11);
        chk("R1 deselected write", int'(vbp_line), int'(m_bp));
        do_read(1'b1, 1'b1, 4'h8, "R1 deselected read");

        do_write(1'b0, 1'b0, 4'h0, 8'hFB);
        do_read(1'b0, 1'b0, 4'h0, "R4 index readback");
        do_write(1'b0, 1'b0, 4'h1, 8'hFF);
        chk_outputs("R4 indexed hi");
        do_write(1'b0, 1'b0, 4'h3, 8'h77);
        chk_outputs("R4 other addr ignored");
        do_read(1'b0, 1'b0, 4'h3, "R4 other addr read");

        do_write(1'b0, 1'b0, 4'h0, 8'h05);
        do_write(1'b0, 1'b0, 4'h1, 8'h5A);
        do_read(1'b0, 1'b0, 4'h1, "R8 unimplemented read");
        chk_outputs("R8 unimplemented write");

        do_write(1'b1, 1'b0, 4'h2, 8'h01);
        chk_outputs("R6 reg mode");
        @(negedge clk); vfil_pin = 1'b0; hfil_pin = 1'b1;
        @(negedge clk); chk_outputs("R6 pins ignored");
        pin_prio = 1'b1;
        @(negedge clk); chk_outputs("R6 pins override");
        pin_prio = 1'b0;

        for (int i = 0; i < 300; i++) begin
            logic dir, sel_n;
            logic [3:0] a;
            dir   = 1'($urandom_range(0, 1));
            sel_n = ($urandom_range(0, 5) == 0);
            if (dir) a = pick_ix();
            else     a = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(2, 15)) : 4'($urandom_range(0, 1));
            if (!dir && a == 0 && $urandom_range(0, 1) == 1) begin
                do_write(dir, sel_n, a, {4'($urandom_range(0, 15)), pick_ix()});
            end else if ($urandom_range(0, 1) == 1) begin
                do_write(dir, sel_n, a, 8'($urandom_range(0, 255)));
            end else begin
                do_read(dir, sel_n, a, "R3 R4 R8 random read");
            end
            if ($urandom_range(0, 9) == 0) begin
                pin_prio = 1'($urandom_range(0, 1));
                vfil_pin = 1'($urandom_range(0, 1));
                hfil_pin = 1'($urandom_range(0, 1));
                @(negedge clk);
            end
            chk_outputs("random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule